// File: doc/BRIEF.md
# Panned-window framebuffer fetch address generator

This block produces the read addresses a display pipeline needs to pull one visible window out of a wider virtual image held in memory. Software programs a start address, a frame length in 32-bit words, a maximum burst length, a visible line length in words, a per-line skip in bytes and a sub-word starting bit. Once enabled, the block issues burst read requests on a request/grant port. It walks the frame line by line. In two-dimensional mode it jumps over the hidden tail of every virtual line. When the last word of the frame has been granted, it returns to the start address.

The start address, the skip and the starting bit are double-buffered. Software writes their shadow copies at any time. The copies move into the working registers at a frame start: either when the engine starts from idle, or at the first frame wrap after software has set the update flag. To reconfigure, software clears the enable bit and polls the busy flag until it drops. A dedicated abort bit stops the engine at once.

Register map (select code on `cfg_sel`): 0 start address, 1 frame setup, 2 control/status, 3 window setup, 4 line length.

Top module: `lcd_fetch_agen`

## Requirements
- R1: After reset no request is raised, and every register reads back as zero.
- R2: The start address register (select 0) keeps the byte address with its two low bits forced to zero, and every request address has its two low bits at zero.
- R3: The frame setup register (select 1) holds the frame length in words in bits 22:0 and the burst length minus one in bits 30:24. `mem_len` carries the granted burst length minus one and never exceeds that field. A request keeps its address and length unchanged until it is granted.
- R4: With control bit 4 clear (linear mode), the address advances by four bytes per granted word across the whole frame. The line length and skip are ignored.
- R5: With control bit 4 set (window mode), a burst never crosses the end of a visible line, whose length in words is held in select 4 bits 15:0. After the last word of a line, the next address also adds the skip from select 3 bits 15:0, with that skip's two low bits ignored.
- R6: A burst never crosses the end of the frame. After the frame's last word is granted, the next request starts again at the start address, with full frame and line counts.
- R7: Writing control bit 3 sets an update-pending flag, which reads back on bit 3. At the next frame wrap, the shadowed start address, skip and starting bit (select 3 bits 28:24) take effect, and the flag clears. Without the flag, shadow writes do not change a running frame sequence.
- R8: Setting control bit 0 (enable) while the engine is idle loads all working values. The first request appears one cycle after the register write takes effect.
- R9: Clearing enable lets the outstanding request complete. Busy (control bit 2) stays high until that grant, and then the engine goes idle.
- R10: Writing control bit 1 (abort) drops any request in the next cycle and clears busy and the update flag. The abort bit always reads zero.
- R11: `first_burst` marks the first request of every frame, and `pix_off` presents the working starting bit that applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Byte address of the burst, word aligned |
| mem_len | output | 7 | Burst length in words minus one |
| mem_gnt | input | 1 | Grant, accepts the current request |
| first_burst | output | 1 | Current request opens a frame |
| pix_off | output | 5 | Starting bit inside the frame's first word |

## Verification
Four configurations are walked burst by burst against an address model built from the requirements. A linear frame with a nonzero skip shows that the skip is ignored. A window whose line is not a multiple of the burst exercises line splitting. A window whose line is shorter than one burst exercises the same split from the other side, and a single-word burst exercises the skip on every line. Grants alternate between immediate and one-cycle delayed, which separates held requests from advancing ones. Directed sequences separate shadow-only writes from flagged updates at a wrap, a graceful disable from an abort, and the start-up latency from the reset state.

// File: rtl/lcd_fetch_pkg.sv
package lcd_fetch_pkg;

  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_FRAME = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_WIN   = 3'd3,
    SEL_LINE  = 3'd4
  } cfg_sel_e;

  localparam int CTL_EN      = 0;
  localparam int CTL_ABORT   = 1;
  localparam int CTL_BUSY    = 2;
  localparam int CTL_UPD     = 3;
  localparam int CTL_2D      = 4;
  localparam int FRM_BL_LSB  = 24;
  localparam int WIN_OFF_LSB = 24;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/fetch_cfg_regs.sv
module fetch_cfg_regs
  import lcd_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FRM_W  = 23,
  parameter int BL_W   = 7,
  parameter int INC_W  = 16,
  parameter int OFF_W  = 5,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy,
  input  logic              load_start,
  input  logic              frame_wrap,
  output logic              en,
  output logic              mode2d,
  output logic              abort,
  output logic              upd_pend,
  output logic [FRM_W-1:0]  frm_size,
  output logic [BL_W-1:0]   bl,
  output logic [LINE_W-1:0] line_words,
  output logic [ADDR_W-1:0] base_sw,
  output logic [ADDR_W-1:0] base_nf,
  output logic [INC_W-3:0]  inc_w,
  output logic [OFF_W-1:0]  off_w
);

  logic              en_q, en_d;
  logic              m2d_q, m2d_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] base_sw_q, base_sw_d, base_w_q, base_w_d;
  logic [FRM_W-1:0]  frm_q, frm_d;
  logic [BL_W-1:0]   bl_q, bl_d;
  logic [INC_W-1:0]  inc_sw_q, inc_sw_d;
  logic [INC_W-3:0]  inc_w_q, inc_w_d;
  logic [OFF_W-1:0]  off_sw_q, off_sw_d, off_w_q, off_w_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              ctrl_wr, upd_wr, apply;

  assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
  assign upd_wr  = ctrl_wr && cfg_wdata[CTL_UPD];
  assign abort   = ctrl_wr && cfg_wdata[CTL_ABORT];
  assign apply   = load_start || (frame_wrap && pend_q);

  always_comb begin
    en_d      = en_q;
    m2d_d     = m2d_q;
    pend_d    = pend_q;
    base_sw_d = base_sw_q;
    base_w_d  = base_w_q;
    frm_d     = frm_q;
    bl_d      = bl_q;
    inc_sw_d  = inc_sw_q;
    inc_w_d   = inc_w_q;
    off_sw_d  = off_sw_q;
    off_w_d   = off_w_q;
    line_d    = line_q;
    if (apply) begin
      base_w_d = base_sw_q;
      inc_w_d  = inc_sw_q[INC_W-1:2];
      off_w_d  = off_sw_q;
      pend_d   = 1'b0;
    end
    if (cfg_we) begin
      case (cfg_sel)
        SEL_BASE:  base_sw_d = {cfg_wdata[ADDR_W-1:2], 2'b00};
        SEL_FRAME: begin
          frm_d = cfg_wdata[FRM_W-1:0];
          bl_d  = cfg_wdata[FRM_BL_LSB +: BL_W];
        end
        SEL_CTRL: begin
          en_d  = cfg_wdata[CTL_EN];
          m2d_d = cfg_wdata[CTL_2D];
          if (cfg_wdata[CTL_UPD]) pend_d = 1'b1;
        end
        SEL_WIN: begin
          inc_sw_d = cfg_wdata[INC_W-1:0];
          off_sw_d = cfg_wdata[WIN_OFF_LSB +: OFF_W];
        end
        SEL_LINE:  line_d = cfg_wdata[LINE_W-1:0];
        default:   ;
      endcase
    end
    if (abort) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      m2d_q     <= 1'b0;
      pend_q    <= 1'b0;
      base_sw_q <= '0;
      base_w_q  <= '0;
      frm_q     <= '0;
      bl_q      <= '0;
      inc_sw_q  <= '0;
      inc_w_q   <= '0;
      off_sw_q  <= '0;
      off_w_q   <= '0;
      line_q    <= '0;
    end else begin
      en_q      <= en_d;
      m2d_q     <= m2d_d;
      pend_q    <= pend_d;
      base_sw_q <= base_sw_d;
      base_w_q  <= base_w_d;
      frm_q     <= frm_d;
      bl_q      <= bl_d;
      inc_sw_q  <= inc_sw_d;
      inc_w_q   <= inc_w_d;
      off_sw_q  <= off_sw_d;
      off_w_q   <= off_w_d;
      line_q    <= line_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_BASE:  cfg_rdata[ADDR_W-1:0] = base_sw_q;
      SEL_FRAME: begin
        cfg_rdata[FRM_W-1:0]         = frm_q;
        cfg_rdata[FRM_BL_LSB +: BL_W] = bl_q;
      end
      SEL_CTRL: begin
        cfg_rdata[CTL_EN]   = en_q;
        cfg_rdata[CTL_BUSY] = busy;
        cfg_rdata[CTL_UPD]  = pend_q;
        cfg_rdata[CTL_2D]   = m2d_q;
      end
      SEL_WIN: begin
        cfg_rdata[INC_W-1:0]            = inc_sw_q;
        cfg_rdata[WIN_OFF_LSB +: OFF_W] = off_sw_q;
      end
      SEL_LINE:  cfg_rdata[LINE_W-1:0] = line_q;
      default:   cfg_rdata = '0;
    endcase
  end

  assign en         = en_q;
  assign mode2d     = m2d_q;
  assign upd_pend   = pend_q;
  assign frm_size   = frm_q;
  assign bl         = bl_q;
  assign line_words = line_q;
  assign base_sw    = base_sw_q;
  assign base_nf    = pend_q ? base_sw_q : base_w_q;
  assign inc_w      = inc_w_q;
  assign off_w      = off_w_q;

endmodule

// File: rtl/fetch_burst_size.sv
module fetch_burst_size #(
  parameter int FRM_W  = 23,
  parameter int BL_W   = 7,
  parameter int LINE_W = 16
) (
  input  logic [FRM_W-1:0]  frm_left,
  input  logic [LINE_W-1:0] line_left,
  input  logic [BL_W-1:0]   bl,
  input  logic              mode2d,
  output logic [FRM_W-1:0]  cnt,
  output logic              line_end,
  output logic              frame_end
);

  logic [FRM_W-1:0] lim, line_ext, by_frame;

  assign lim      = FRM_W'(bl) + FRM_W'(1);
  assign line_ext = FRM_W'(line_left);
  assign by_frame = (frm_left < lim) ? frm_left : lim;

  always_comb begin
    cnt = by_frame;
    if (mode2d && (line_ext < by_frame)) cnt = line_ext;
  end

  assign frame_end = (frm_left == cnt);
  assign line_end  = mode2d && (line_ext == cnt);

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import lcd_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FRM_W  = 23,
  parameter int BL_W   = 7,
  parameter int INC_W  = 16,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode2d,
  input  logic              abort,
  input  logic [FRM_W-1:0]  frm_size,
  input  logic [LINE_W-1:0] line_words,
  input  logic [ADDR_W-1:0] base_sw,
  input  logic [ADDR_W-1:0] base_nf,
  input  logic [INC_W-3:0]  inc_w,
  input  logic              gnt,
  input  logic [FRM_W-1:0]  cnt,
  input  logic              line_end,
  input  logic              frame_end,
  output logic [FRM_W-1:0]  frm_left,
  output logic [LINE_W-1:0] line_left,
  output logic              req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BL_W-1:0]   req_len,
  output logic              req_first,
  output logic              busy,
  output logic              load_start,
  output logic              frame_wrap
);

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d, step, skip;
  logic [FRM_W-1:0]  frm_q, frm_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              first_q, first_d;
  logic              start_ok;

  assign start_ok = en && (frm_size != '0) && (!mode2d || (line_words != '0));
  assign step     = ADDR_W'(cnt) << 2;
  assign skip     = ADDR_W'({inc_w, 2'b00});

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    frm_d      = frm_q;
    line_d     = line_q;
    first_d    = first_q;
    load_start = 1'b0;
    frame_wrap = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_ok && !abort) begin
          st_d       = ST_REQ;
          addr_d     = base_sw;
          frm_d      = frm_size;
          line_d     = line_words;
          first_d    = 1'b1;
          load_start = 1'b1;
        end
      end
      ST_REQ: begin
        if (abort) begin
          st_d = ST_IDLE;
        end else if (gnt) begin
          first_d = 1'b0;
          if (frame_end) begin
            addr_d     = base_nf;
            frm_d      = frm_size;
            line_d     = line_words;
            first_d    = 1'b1;
            frame_wrap = 1'b1;
          end else if (line_end) begin
            addr_d = addr_q + step + skip;
            frm_d  = frm_q - cnt;
            line_d = line_words;
          end else begin
            addr_d = addr_q + step;
            frm_d  = frm_q - cnt;
            line_d = line_q - LINE_W'(cnt);
          end
          if (!en) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      frm_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      frm_q   <= frm_d;
      line_q  <= line_d;
      first_q <= first_d;
    end
  end

  assign frm_left  = frm_q;
  assign line_left = line_q;
  assign req       = (st_q == ST_REQ);
  assign busy      = (st_q == ST_REQ);
  assign req_addr  = addr_q;
  assign req_len   = BL_W'(cnt - FRM_W'(1));
  assign req_first = first_q && (st_q == ST_REQ);

endmodule

// File: rtl/lcd_fetch_agen.sv
module lcd_fetch_agen
  import lcd_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FRM_W  = 23,
  parameter int BL_W   = 7,
  parameter int INC_W  = 16,
  parameter int OFF_W  = 5,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BL_W-1:0]   mem_len,
  input  logic              mem_gnt,
  output logic              first_burst,
  output logic [OFF_W-1:0]  pix_off
);

  logic              rst_meta, rst_n_s;
  logic              en, mode2d, abort, upd_pend, busy;
  logic              load_start, frame_wrap;
  logic [FRM_W-1:0]  frm_size, frm_left, cnt;
  logic [BL_W-1:0]   bl_sw;
  logic [LINE_W-1:0] line_words, line_left;
  logic [ADDR_W-1:0] base_sw, base_nf;
  logic [INC_W-3:0]  inc_w;
  logic              line_end, frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  fetch_cfg_regs #(
    .ADDR_W(ADDR_W), .FRM_W(FRM_W), .BL_W(BL_W),
    .INC_W(INC_W), .OFF_W(OFF_W), .LINE_W(LINE_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .busy       (busy),
    .load_start (load_start),
    .frame_wrap (frame_wrap),
    .en         (en),
    .mode2d     (mode2d),
    .abort      (abort),
    .upd_pend   (upd_pend),
    .frm_size   (frm_size),
    .bl         (bl_sw),
    .line_words (line_words),
    .base_sw    (base_sw),
    .base_nf    (base_nf),
    .inc_w      (inc_w),
    .off_w      (pix_off)
  );

  fetch_burst_size #(
    .FRM_W(FRM_W), .BL_W(BL_W), .LINE_W(LINE_W)
  ) u_size (
    .frm_left  (frm_left),
    .line_left (line_left),
    .bl        (bl_sw),
    .mode2d    (mode2d),
    .cnt       (cnt),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  fetch_sequencer #(
    .ADDR_W(ADDR_W), .FRM_W(FRM_W), .BL_W(BL_W),
    .INC_W(INC_W), .LINE_W(LINE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en         (en),
    .mode2d     (mode2d),
    .abort      (abort),
    .frm_size   (frm_size),
    .line_words (line_words),
    .base_sw    (base_sw),
    .base_nf    (base_nf),
    .inc_w      (inc_w),
    .gnt        (mem_gnt),
    .cnt        (cnt),
    .line_end   (line_end),
    .frame_end  (frame_end),
    .frm_left   (frm_left),
    .line_left  (line_left),
    .req        (mem_req),
    .req_addr   (mem_addr),
    .req_len    (mem_len),
    .req_first  (first_burst),
    .busy       (busy),
    .load_start (load_start),
    .frame_wrap (frame_wrap)
  );

endmodule

// File: rtl/fetch_agen_checker.sv
module fetch_agen_checker
  import lcd_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BL_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_sel,
  input logic [31:0]       cfg_wdata,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BL_W-1:0]   mem_len,
  input logic              mem_gnt,
  input logic              first_burst,
  input logic [BL_W-1:0]   bl,
  input logic              upd_pend,
  input logic              frame_wrap,
  input logic              load_start
);

  logic abort_w, upd_w;
  assign abort_w = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[CTL_ABORT];
  assign upd_w   = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[CTL_UPD];

  // R3: an ungranted request holds its address and length
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !abort_w |=> mem_req && $stable(mem_addr) && $stable(mem_len));

  // R3: burst length bounded by the programmed field
  p_len_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_len <= bl);

  // R2: request addresses are word aligned
  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R10: abort removes the request in the next cycle
  p_abort_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> !mem_req);

  // R7: a pending update is consumed at a frame start
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pend && (frame_wrap || load_start) && !upd_w |=> !upd_pend);

  // R11: a request raised from idle opens a frame
  p_first_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> first_burst);

endmodule

bind lcd_fetch_agen fetch_agen_checker #(
  .ADDR_W(ADDR_W), .BL_W(BL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_len     (mem_len),
  .mem_gnt     (mem_gnt),
  .first_burst (first_burst),
  .bl          (bl_sw),
  .upd_pend    (upd_pend),
  .frame_wrap  (frame_wrap),
  .load_start  (load_start)
);

// File: tb/tb_lcd_fetch_agen.sv
module tb_lcd_fetch_agen;

  localparam int CLK_P = 10;
  localparam int NV    = 4;

  localparam logic [31:0] T_2D   [NV] = '{32'd0, 32'd1, 32'd1, 32'd1};
  localparam logic [31:0] T_BASE [NV] = '{32'h1000, 32'h2003, 32'h3000, 32'h4008};
  localparam logic [31:0] T_FS   [NV] = '{32'd20, 32'd24, 32'd12, 32'd6};
  localparam logic [31:0] T_BL   [NV] = '{32'd7, 32'd7, 32'd7, 32'd0};
  localparam logic [31:0] T_LINE [NV] = '{32'd5, 32'd10, 32'd4, 32'd3};
  localparam logic [31:0] T_INC  [NV] = '{32'h40, 32'd24, 32'h12, 32'd8};

  logic        clk, rst_n, cfg_we, mem_gnt, mem_req, first_burst;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr;
  logic [6:0]  mem_len;
  logic [4:0]  pix_off;

  int n_tests = 0;
  int n_fail  = 0;

  lcd_fetch_agen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
    .first_burst(first_burst), .pix_off(pix_off)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    cfg_sel = s;
    #1;
    d = cfg_rdata;
  endtask

  task automatic take_burst(input string rq, input logic [31:0] ea, input int el,
                            input bit ef, input bit dly);
    int k = 0;
    while (!mem_req && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk(mem_req, rq, 32'(mem_req), 32'd1);
    chk(mem_addr == ea, rq, mem_addr, ea);
    chk(32'(mem_len) == 32'(el), "R3 len", 32'(mem_len), 32'(el));
    chk(first_burst == ef, "R11 first", 32'(first_burst), 32'(ef));
    if (dly) @(negedge clk);
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired, run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rv, e_addr, e_fl, e_ll, c_base, c_inc;
    int          e_len;
    bit          e_first, c_2d;
    cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = '0; mem_gnt = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(!mem_req, "R1 req", 32'(mem_req), 32'd0);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), rv);
      chk(rv == 32'd0, "R1 reg", rv, 32'd0);
    end

    // table of configurations walked by one loop
    for (int i = 0; i < NV; i++) begin
      c_2d   = T_2D[i][0];
      c_base = T_BASE[i];
      c_inc  = T_INC[i];
      @(negedge clk);
      wr(3'd0, c_base);
      wr(3'd1, T_FS[i] | (T_BL[i] << 24));
      wr(3'd3, c_inc | (32'((i * 9 + 3) % 32) << 24));
      wr(3'd4, T_LINE[i]);
      rd(3'd0, rv);
      chk(rv == (c_base & ~32'd3), "R2 base readback", rv, c_base & ~32'd3);
      @(negedge clk);
      wr(3'd2, 32'd1 | (32'(c_2d) << 4));
      chk(!mem_req, "R8 not yet", 32'(mem_req), 32'd0);
      @(negedge clk);
      chk(mem_req, "R8 start", 32'(mem_req), 32'd1);
      chk(32'(pix_off) == 32'((i * 9 + 3) % 32), "R11 pix_off", 32'(pix_off), 32'((i * 9 + 3) % 32));
      e_addr = c_base & ~32'd3; e_fl = T_FS[i]; e_ll = T_LINE[i]; e_first = 1'b1;
      for (int j = 0; j < 8; j++) begin
        e_len = int'(T_BL[i]) + 1;
        if (int'(e_fl) < e_len) e_len = int'(e_fl);
        if (c_2d && int'(e_ll) < e_len) e_len = int'(e_ll);
        take_burst((e_first && j > 0) ? "R6 wrap" : (c_2d ? "R5 window" : "R4 linear"),
                   e_addr, e_len - 1, e_first, j[0]);
        e_first = 1'b0;
        if (int'(e_fl) == e_len) begin
          e_addr = c_base & ~32'd3; e_fl = T_FS[i]; e_ll = T_LINE[i]; e_first = 1'b1;
        end else if (c_2d && int'(e_ll) == e_len) begin
          e_addr = e_addr + 32'(4 * e_len) + (c_inc & ~32'd3);
          e_fl = e_fl - 32'(e_len); e_ll = T_LINE[i];
        end else begin
          e_addr = e_addr + 32'(4 * e_len);
          e_fl = e_fl - 32'(e_len); e_ll = e_ll - 32'(e_len);
        end
      end
      wr(3'd2, 32'd2);
    end

    // R7: shadow writes wait for the update flag and the frame wrap
    @(negedge clk);
    wr(3'd0, 32'h5000);
    wr(3'd1, 32'd8 | (32'd7 << 24));
    wr(3'd3, 32'd0 | (32'd4 << 24));
    wr(3'd2, 32'd1);
    take_burst("R7 first frame", 32'h5000, 7, 1'b1, 1'b0);
    wr(3'd0, 32'h6000);
    wr(3'd3, 32'd0 | (32'd9 << 24));
    take_burst("R7 no update", 32'h5000, 7, 1'b1, 1'b0);
    chk(pix_off == 5'd4, "R7 offset held", 32'(pix_off), 32'd4);
    wr(3'd2, 32'h9);
    rd(3'd2, rv);
    chk(rv[3], "R7 pending set", rv, rv | 32'h8);
    take_burst("R7 last old frame", 32'h5000, 7, 1'b1, 1'b0);
    rd(3'd2, rv);
    chk(!rv[3], "R7 pending cleared", rv, rv & ~32'h8);
    chk(pix_off == 5'd9, "R7 offset applied", 32'(pix_off), 32'd9);
    take_burst("R7 new base", 32'h6000, 7, 1'b1, 1'b0);

    // R9: disable completes the outstanding request
    wr(3'd2, 32'd0);
    chk(mem_req, "R9 request kept", 32'(mem_req), 32'd1);
    rd(3'd2, rv);
    chk(rv[2], "R9 busy high", rv, rv | 32'h4);
    take_burst("R9 final burst", 32'h6000, 7, 1'b1, 1'b0);
    chk(!mem_req, "R9 idle", 32'(mem_req), 32'd0);
    rd(3'd2, rv);
    chk(!rv[2], "R9 busy low", rv, rv & ~32'h4);

    // R10: abort drops the request and the pending flag
    @(negedge clk);
    wr(3'd2, 32'd1);
    @(negedge clk);
    chk(mem_req, "R10 running", 32'(mem_req), 32'd1);
    wr(3'd2, 32'h9);
    wr(3'd2, 32'h2);
    chk(!mem_req, "R10 dropped", 32'(mem_req), 32'd0);
    rd(3'd2, rv);
    chk(rv == 32'd0, "R10 status", rv, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule